// File: doc/BRIEF.md
# Program Counter Latch Unit

This block keeps a byte-addressed 21-bit program counter for a small processor core. The counter is split into a low byte, a high byte and a 5-bit upper field. Software cannot reach the two upper parts directly. Instead, a pair of holding registers stands between software and those parts. Reading the low byte copies the current high and upper bits into the holding registers. Writing the low byte, either with a plain store or with an add whose result goes to the low byte, rebuilds the whole counter from the holding registers and the new byte.

Each instruction normally advances the counter by two. A branch loads an absolute target. Any change of flow (branch, low-byte write or low-byte add) moves a small control machine from state `ST_SEQ` (sequential) to state `ST_REDIR` for one cycle. In that cycle the `redirect` output is high and the increment is ignored, so the instruction already in flight is dropped and the next one comes from the new address. The transitions are:
- `SEQ_TO_REDIR` on a jump taken in `ST_SEQ`.
- `REDIR_HOLD` on a further jump taken in `ST_REDIR`.
- `REDIR_TO_SEQ` when no jump is taken in `ST_REDIR`.
- `SEQ_STAY` when no jump is taken in `ST_SEQ`.

Because the add-to-low-byte path does not refresh the holding registers, software that computes a jump must read the low byte first.

Top module: `pc_latch_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pc` is 0, both holding registers are 0 and `redirect` is 0.
- R2: `lo_rdata` always shows `pc[7:0]`. When `lo_rd` is high at a clock edge, from the next cycle the holding registers equal `pc[15:8]` and `pc[20:16]` as they were at that edge.
- R3: The holding registers change only through `lo_rd`. Branch, write, add and increment leave them unchanged.
- R4: An accepted low-byte write sets `pc` to {`hold_up`, `hold_hi`, `lo_wdata` with bit 0 cleared}, using the holding values from before the edge.
- R5: An accepted low-byte add sets `pc` to {`hold_up`, `hold_hi`, (`pc[7:0]` + `lo_wdata`) mod 256 with bit 0 cleared}. The carry out of the low byte is discarded.
- R6: In state `ST_SEQ`, an accepted increment adds 2 to `pc`, wrapping modulo 2^21.
- R7: A branch loads `pc` with `br_tgt` with bit 0 cleared.
- R8: When several operations are requested in one cycle, priority is branch, then write, then add, then increment. Only the winner takes effect. A same-cycle `lo_rd` still refreshes the holding registers from the pre-edge `pc`.
- R9: `redirect` is high in exactly the cycle after an accepted branch, write or add. In that cycle (state `ST_REDIR`) an increment request has no effect on `pc`.
- R10: `pc[0]` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance counter by one instruction |
| lo_rd | input | 1 | Low-byte read strobe; refreshes holding registers |
| lo_wr | input | 1 | Low-byte write strobe |
| lo_add | input | 1 | Add `lo_wdata` to the low byte |
| lo_wdata | input | 8 | Write data or add operand |
| br_en | input | 1 | Absolute branch request |
| br_tgt | input | 21 | Branch target address |
| pc | output | 21 | Current program counter |
| lo_rdata | output | 8 | Low-byte read data |
| hold_hi | output | 8 | High holding register |
| hold_up | output | 5 | Upper holding register |
| redirect | output | 1 | Flow change in progress; in-flight fetch dropped |

## Verification
A holding register that is refreshed at the wrong time, or not refreshed at all, shows up on `hold_hi`/`hold_up` one cycle after the strobe. It also corrupts the upper bits of `pc` on the next low-byte write or add. The bench therefore places branches between a read and a write, so that stale and fresh holding values differ. A state machine stuck in the wrong state shows in the very next cycle: `redirect` is wrong, or `pc` moves by 2 when it should hold. A carry leaking into the upper bits appears in `pc[20:8]` on the cycle after the add.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic {
        ST_SEQ   = 1'b0,
        ST_REDIR = 1'b1
    } pcu_state_t;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_BR   = 3'd1,
        OP_WR   = 3'd2,
        OP_ADD  = 3'd3,
        OP_STEP = 3'd4
    } pcu_op_t;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    step_en,
    input  logic    lo_wr,
    input  logic    lo_add,
    input  logic    br_en,
    output pcu_op_t op,
    output logic    redirect
);

    pcu_state_t state_q, state_d;
    logic       jump;

    // Operation selection: branch beats write beats add beats step (R8)
    always_comb begin
        op = OP_NONE;
        if (br_en)
            op = OP_BR;
        else if (lo_wr)
            op = OP_WR;
        else if (lo_add)
            op = OP_ADD;
        else if (step_en && state_q == ST_SEQ)
            op = OP_STEP;
    end

    assign jump = br_en | lo_wr | lo_add;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:   state_d = jump ? ST_REDIR : ST_SEQ;   // SEQ_TO_REDIR / SEQ_STAY
            ST_REDIR: state_d = jump ? ST_REDIR : ST_SEQ;   // REDIR_HOLD / REDIR_TO_SEQ
            default:  state_d = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SEQ;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_SEQ:   redirect = 1'b0;
            ST_REDIR: redirect = 1'b1;
            default:  redirect = 1'b0;
        endcase
    end

    // R9: redirect follows every flow change for one cycle
    p_redirect_after_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en || lo_wr || lo_add) |=> redirect)
        else $error("redirect missing after jump");

    p_redirect_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_en || lo_wr || lo_add) |=> !redirect)
        else $error("redirect without jump");

endmodule

// File: rtl/pcu_hold.sv
module pcu_hold #(
    parameter int unsigned HI_W = 8,
    parameter int unsigned UP_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [HI_W-1:0] src_hi,
    input  logic [UP_W-1:0] src_up,
    output logic [HI_W-1:0] hold_hi,
    output logic [UP_W-1:0] hold_up
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_hi <= '0;
            hold_up <= '0;
        end else if (load) begin
            hold_hi <= src_hi;
            hold_up <= src_up;
        end
    end

    p_refresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hold_hi == $past(src_hi)) && (hold_up == $past(src_up)))
        else $error("holding refresh wrong");

    p_no_refresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold_hi) && $stable(hold_up))
        else $error("holding changed without read");

endmodule

// File: rtl/pcu_next.sv
module pcu_next
    import pcu_pkg::*;
#(
    parameter int unsigned LO_W = 8,
    parameter int unsigned HI_W = 8,
    parameter int unsigned UP_W = 5,
    parameter int unsigned STEP = 2,
    localparam int unsigned PC_W = LO_W + HI_W + UP_W
) (
    input  pcu_op_t         op,
    input  logic [PC_W-1:0] pc_q,
    input  logic [LO_W-1:0] wdata,
    input  logic [PC_W-1:0] br_tgt,
    input  logic [HI_W-1:0] hold_hi,
    input  logic [UP_W-1:0] hold_up,
    output logic [PC_W-1:0] pc_d
);

    localparam logic [LO_W-1:0] LO_MASK = ~LO_W'(1);
    localparam logic [PC_W-1:0] PC_MASK = ~PC_W'(1);

    logic [LO_W-1:0] lo_sum;

    // Carry out of the low byte is dropped (R5)
    assign lo_sum = pc_q[LO_W-1:0] + wdata;

    always_comb begin
        pc_d = pc_q;
        unique case (op)
            OP_BR:   pc_d = br_tgt & PC_MASK;
            OP_WR:   pc_d = {hold_up, hold_hi, wdata & LO_MASK};
            OP_ADD:  pc_d = {hold_up, hold_hi, lo_sum & LO_MASK};
            OP_STEP: pc_d = (pc_q + PC_W'(STEP)) & PC_MASK;
            OP_NONE: pc_d = pc_q;
            default: pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pc_latch_unit.sv
module pc_latch_unit
    import pcu_pkg::*;
#(
    parameter int unsigned LO_W = 8,
    parameter int unsigned HI_W = 8,
    parameter int unsigned UP_W = 5,
    parameter int unsigned STEP = 2,
    localparam int unsigned PC_W = LO_W + HI_W + UP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic            lo_rd,
    input  logic            lo_wr,
    input  logic            lo_add,
    input  logic [LO_W-1:0] lo_wdata,
    input  logic            br_en,
    input  logic [PC_W-1:0] br_tgt,
    output logic [PC_W-1:0] pc,
    output logic [LO_W-1:0] lo_rdata,
    output logic [HI_W-1:0] hold_hi,
    output logic [UP_W-1:0] hold_up,
    output logic            redirect
);

    pcu_op_t         op;
    logic [PC_W-1:0] pc_d;

    pcu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .lo_wr    (lo_wr),
        .lo_add   (lo_add),
        .br_en    (br_en),
        .op       (op),
        .redirect (redirect)
    );

    pcu_hold #(.HI_W(HI_W), .UP_W(UP_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lo_rd),
        .src_hi  (pc[LO_W+HI_W-1:LO_W]),
        .src_up  (pc[PC_W-1:LO_W+HI_W]),
        .hold_hi (hold_hi),
        .hold_up (hold_up)
    );

    pcu_next #(.LO_W(LO_W), .HI_W(HI_W), .UP_W(UP_W), .STEP(STEP)) u_next (
        .op      (op),
        .pc_q    (pc),
        .wdata   (lo_wdata),
        .br_tgt  (br_tgt),
        .hold_hi (hold_hi),
        .hold_up (hold_up),
        .pc_d    (pc_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_d;
    end

    assign lo_rdata = pc[LO_W-1:0];

    p_bit0_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc[0] == 1'b0)
        else $error("pc bit 0 set");

    p_write_forms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !br_en) |=> pc == {$past(hold_up), $past(hold_hi), $past(lo_wdata) & ~LO_W'(1)})
        else $error("write formed wrong pc");

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !redirect && !br_en && !lo_wr && !lo_add) |=> pc == $past(pc) + PC_W'(STEP))
        else $error("step wrong");

    p_step_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !br_en && !lo_wr && !lo_add) |=> $stable(pc))
        else $error("pc moved during redirect");

    p_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_en |=> pc == ($past(br_tgt) & ~PC_W'(1)))
        else $error("branch target wrong");

endmodule

// File: tb/sim_pc_latch_unit.sv
module sim_pc_latch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0, lo_rd = 1'b0, lo_wr = 1'b0, lo_add = 1'b0, br_en = 1'b0;
    logic [7:0]  lo_wdata = '0;
    logic [20:0] br_tgt = '0;
    logic [20:0] pc;
    logic [7:0]  lo_rdata;
    logic [7:0]  hold_hi;
    logic [4:0]  hold_up;
    logic        redirect;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [20:0] pc;
        logic [7:0]  hi;
        logic [4:0]  up;
        logic        rd;
        string       tag;
    } exp_t;

    exp_t q[$];

    // reference state
    logic [20:0] m_pc = '0;
    logic [7:0]  m_hi = '0;
    logic [4:0]  m_up = '0;
    logic        m_rd = 1'b0;

    always #2 clk = ~clk;

    pc_latch_unit u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .lo_rd(lo_rd), .lo_wr(lo_wr),
        .lo_add(lo_add), .lo_wdata(lo_wdata), .br_en(br_en), .br_tgt(br_tgt),
        .pc(pc), .lo_rdata(lo_rdata), .hold_hi(hold_hi), .hold_up(hold_up), .redirect(redirect)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected outcome
    task automatic drive(input bit st, input bit rd, input bit wr, input bit ad, input bit br,
                         input logic [7:0] wd, input logic [20:0] tgt, input string tag);
        exp_t e;
        logic [20:0] npc;
        logic [7:0]  s;
        @(negedge clk);
        step_en = st; lo_rd = rd; lo_wr = wr; lo_add = ad; br_en = br;
        lo_wdata = wd; br_tgt = tgt;
        chk(lo_rdata == m_pc[7:0], "R2 lo_rdata", {24'd0, lo_rdata}, {24'd0, m_pc[7:0]});
        npc = m_pc;
        if (br) npc = {tgt[20:1], 1'b0};
        else if (wr) npc = {m_up, m_hi, wd[7:1], 1'b0};
        else if (ad) begin
            s = m_pc[7:0] + wd;
            npc = {m_up, m_hi, s[7:1], 1'b0};
        end else if (st && !m_rd) npc = m_pc + 21'd2;
        if (rd) begin
            m_hi = m_pc[15:8];
            m_up = m_pc[20:16];
        end
        m_pc = npc;
        m_rd = br | wr | ad;
        e.pc = m_pc; e.hi = m_hi; e.up = m_up; e.rd = m_rd; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 8'h00, 21'h0, "R9 idle");
    endtask

    // Monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(pc == e.pc, {e.tag, " pc"}, {11'd0, pc}, {11'd0, e.pc});
            chk(hold_hi == e.hi, "R3 hold_hi", {24'd0, hold_hi}, {24'd0, e.hi});
            chk(hold_up == e.up, "R3 hold_up", {27'd0, hold_up}, {27'd0, e.up});
            chk(redirect == e.rd, "R9 redirect", {31'd0, redirect}, {31'd0, e.rd});
            chk(pc[0] == 1'b0, "R10 bit0", {31'd0, pc[0]}, 32'd0);
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(pc == 21'd0 && hold_hi == 8'd0 && hold_up == 5'd0 && !redirect, "R1 in reset",
            {11'd0, pc}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(pc == 21'd0 && !redirect, "R1 after reset", {11'd0, pc}, 32'd0);

        // R6 sequential steps
        drive(1, 0, 0, 0, 0, 8'h00, 21'h0, "R6 step");
        drive(1, 0, 0, 0, 0, 8'h00, 21'h0, "R6 step");
        drive(1, 0, 0, 0, 0, 8'h00, 21'h0, "R6 step");
        // R7 branch with odd target, then step ignored during redirect (R9)
        drive(0, 0, 0, 0, 1, 8'h00, 21'h12345, "R7 branch");
        drive(1, 0, 0, 0, 0, 8'h00, 21'h0, "R9 step blocked");
        drive(1, 0, 0, 0, 0, 8'h00, 21'h0, "R6 step after redir");
        // R2 read refreshes holding registers
        drive(0, 1, 0, 0, 0, 8'h00, 21'h0, "R2 read");
        // branch away; R5 add uses stale holding values, carry dropped
        drive(0, 0, 0, 0, 1, 8'h00, 21'h0ABCFE, "R7 branch far");
        idle(1);
        drive(0, 0, 0, 1, 0, 8'h10, 21'h0, "R5 add carry");
        idle(1);
        // R4 write with odd data
        drive(0, 0, 1, 0, 0, 8'h57, 21'h0, "R4 write");
        idle(1);
        // R8 priority cases
        drive(1, 0, 1, 1, 1, 8'h22, 21'h004400, "R8 branch wins");
        drive(1, 0, 1, 1, 0, 8'h22, 21'h0, "R8 write wins");
        drive(1, 0, 0, 1, 0, 8'h06, 21'h0, "R8 add wins");
        // R8 read with write in the same cycle
        drive(0, 0, 0, 0, 1, 8'h00, 21'h1F0210, "R7 branch");
        drive(0, 1, 1, 0, 0, 8'h80, 21'h0, "R8 read+write");
        drive(0, 0, 1, 0, 0, 8'h40, 21'h0, "R4 write new hold");
        // R6 wrap
        drive(0, 0, 0, 0, 1, 8'h00, 21'h1FFFFE, "R7 branch top");
        idle(1);
        drive(1, 0, 0, 0, 0, 8'h00, 21'h0, "R6 wrap");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom;
            drive(r[0] | r[1], r[2] & r[3], (r[7:4] == 4'd0), (r[11:8] == 4'd1),
                  (r[15:12] == 4'd2), r[23:16], 21'($urandom), "R8 mixed");
        end
        idle(2);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule